// File: doc/BRIEF.md
# SDRAM Controller with Power-Up Sequencing and Refresh

This block drives a single 32-bit SDRAM with four banks, a 12-bit row, an 8-bit column and two bank-select bits. After reset it waits out a settling period. It then runs a fixed start-up sequence and programs the mode register for single-beat bursts at the chosen CAS latency. From then on it serves one user read or write at a time. Each access is an activate followed by a read or write carrying auto-precharge, so the controller never issues a precharge during normal traffic.

A refresh timer raises a refresh debt every `REF_INTERVAL` cycles. The debt saturates at two. Owed refreshes are served before any new request is accepted, and a debt of two is cleared with two back-to-back refreshes. Users hand in requests with a valid/ready handshake. Read data comes back with a one-cycle valid flag once the CAS latency has elapsed. All delays are counted in clock cycles and set by parameters.

Top module: `sdctl_top`

## Requirements
- R1: While reset is held, the strobes show deselect (chip select, RAS, CAS, WE all high). After reset is released the pins show only no-op (L,H,H,H) until the precharge-all of R2 appears, on the cycle after the `INIT_CYC`-th rising edge.
- R2: Start-up runs in this order: precharge (L,L,H,L) with the auto-precharge pin high, meaning all banks; then auto refresh (L,L,L,H) `T_RP` cycles later; then mode set (L,L,L,L) `T_RFC` cycles later; then auto refresh `T_MRD` cycles later. `reqReady` stays low throughout, and no activate comes within `T_MRD` cycles of the mode set.
- R3: The mode word on the address pins carries burst length 1 in bits 2:0 (value 000), sequential type in bit 3 (0), `CAS_LAT` in bits 6:4, and zeros in bits 11:7. The bank pins are zero.
- R4: In idle with no refresh owed, `reqReady` is high and a request is taken on a clock edge with `reqValid` high. An activate (L,L,H,H) then appears on the next cycle, with bank = `reqAddr[21:20]` and row = `reqAddr[19:8]`. `reqReady` is low on the cycle after an acceptance.
- R5: Exactly `T_RCD` cycles after the activate, a write (L,H,L,L) or read (L,H,L,H) appears. It has the auto-precharge pin high, the column `reqAddr[7:0]` on address bits 7:0, zeros above, and the same bank.
- R6: A write puts `reqWdata` on the data output and `reqMask` on the byte masks on the write command cycle. Mask bit i high blocks byte i (bits 8i+7:8i). The output enable is high on that cycle only.
- R7: The data input is sampled `CAS_LAT` cycles after a read command is on the pins. `rspValid` is high for one cycle on the following cycle, with that data on `rspData`.
- R8: After a read or write, the next command waits at least the largest of `T_RC`−`T_RCD`, `T_RAS`−`T_RCD`+`T_RP`, `CAS_LAT`+`T_RP` and `T_RDL`+`T_RP` cycles. Activates are at least `T_RC` apart.
- R9: The refresh debt gains one every `REF_INTERVAL` cycles, up to two. Owed refreshes go out, `T_RFC` apart, before any request is accepted. Over a long run the number of refreshes keeps pace with the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | User request present |
| reqReady | output | 1 | Request taken on this edge when valid |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 22 | {bank, row, column} |
| reqWdata | input | 32 | Write data |
| reqMask | input | 4 | Byte masks, 1 blocks a byte |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write strobe, active low |
| sdAddr | output | 12 | Row, column or mode word |
| sdAutoPre | output | 1 | Auto-precharge / precharge-all bit |
| sdBank | output | 2 | Bank select |
| sdDqm | output | 4 | Byte data masks |
| sdDqOut | output | 32 | Write data to the memory |
| sdDqOe | output | 1 | Data output enable |
| sdDqIn | input | 32 | Read data from the memory |

## Verification
The assertions check four rules on every cycle at the pins:
- each column command follows its activate by exactly `T_RCD`;
- activates are spaced by `T_RC` and clear the mode-set gap;
- a read response is only flagged `CAS_LAT` cycles after a read command;
- the data bus is driven only with a write.

Other behaviours only the bench scenarios can show. These are the exact start-up order and mode word, the merging of masked bytes, the returned read values, and the handling of a refresh debt of two that builds up during start-up while a request is already waiting. The same holds for the long-run refresh rate under a continuous stream of requests.

// File: rtl/sdctl_pkg.sv
package sdctl_pkg;

  // {chip select, RAS, CAS, WE}, all active low
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdCmd_e;

  typedef enum logic [1:0] {
    ADDR_NONE = 2'd0,
    ADDR_ROW  = 2'd1,
    ADDR_COL  = 2'd2,
    ADDR_MODE = 2'd3
  } addrSel_e;

  typedef struct packed {
    sdCmd_e   cmd;
    addrSel_e addrSel;
    logic     apBit;
    logic     takeReq;
  } ctlStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdctl_ctrl.sv
module sdctl_ctrl
  import sdctl_pkg::*;
#(
  parameter int INIT_CYC     = 10000,
  parameter int REF_INTERVAL = 780,
  parameter int CAS_LAT      = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_RDL        = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t stb
);

  localparam int POST_RW = maxOf(maxOf(T_RC - T_RCD, T_RAS - T_RCD + T_RP),
                                 maxOf(CAS_LAT + T_RP, T_RDL + T_RP));
  localparam int TMR_MAX = maxOf(maxOf(INIT_CYC, T_RFC), maxOf(POST_RW, maxOf(T_RCD, maxOf(T_RP, T_MRD))));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {
    ST_IPRE, ST_IREF1, ST_IMRS, ST_IREF2, ST_IDLE, ST_ACCESS
  } ctlState_e;

  ctlState_e        state, stateNext;
  logic [TMR_W-1:0] timer, timerNext;
  logic [REF_W-1:0] refCnt;
  logic [1:0]       refOwed;
  logic             refTick, refTaken;
  logic             accWrite;

  always_comb begin
    stb         = '0;
    stb.cmd     = CMD_NOP;
    stb.addrSel = ADDR_NONE;
    stateNext   = state;
    timerNext   = timer;
    refTaken    = 1'b0;
    reqReady    = 1'b0;
    if (timer != '0) begin
      timerNext = timer - 1'b1;
    end else begin
      unique case (state)
        ST_IPRE: begin
          stb.cmd   = CMD_PRE;
          stb.apBit = 1'b1;
          timerNext = TMR_W'(T_RP - 1);
          stateNext = ST_IREF1;
        end
        ST_IREF1: begin
          stb.cmd   = CMD_REF;
          timerNext = TMR_W'(T_RFC - 1);
          stateNext = ST_IMRS;
        end
        ST_IMRS: begin
          stb.cmd     = CMD_MRS;
          stb.addrSel = ADDR_MODE;
          timerNext   = TMR_W'(T_MRD - 1);
          stateNext   = ST_IREF2;
        end
        ST_IREF2: begin
          stb.cmd   = CMD_REF;
          timerNext = TMR_W'(T_RFC - 1);
          stateNext = ST_IDLE;
        end
        ST_IDLE: begin
          if (refOwed != 2'd0) begin
            stb.cmd   = CMD_REF;
            refTaken  = 1'b1;
            timerNext = TMR_W'(T_RFC - 1);
          end else begin
            reqReady = 1'b1;
            if (reqValid) begin
              stb.cmd     = CMD_ACT;
              stb.addrSel = ADDR_ROW;
              stb.takeReq = 1'b1;
              timerNext   = TMR_W'(T_RCD - 1);
              stateNext   = ST_ACCESS;
            end
          end
        end
        ST_ACCESS: begin
          stb.cmd     = accWrite ? CMD_WR : CMD_RD;
          stb.addrSel = ADDR_COL;
          stb.apBit   = 1'b1;
          timerNext   = TMR_W'(POST_RW - 1);
          stateNext   = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign refTick = (refCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IPRE;
      timer    <= TMR_W'(INIT_CYC - 1);
      refCnt   <= REF_W'(REF_INTERVAL - 1);
      refOwed  <= 2'd0;
      accWrite <= 1'b0;
    end else begin
      state <= stateNext;
      timer <= timerNext;
      refCnt <= refTick ? REF_W'(REF_INTERVAL - 1) : refCnt - 1'b1;
      unique case ({refTick, refTaken})
        2'b10:   if (refOwed != 2'd2) refOwed <= refOwed + 2'd1;
        2'b01:   refOwed <= refOwed - 2'd1;
        default: ;
      endcase
      if (stb.takeReq) accWrite <= reqWrite;
    end
  end

  AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> !reqReady) else $error("second accept without access"); // R4
  AST_DEBT_SERVED: assert property (@(posedge clk) disable iff (!rstN) (refOwed == 2'd2 && state == ST_IDLE && timer == '0) |-> !stb.takeReq) else $error("request taken over owed refresh"); // R9

endmodule

// File: rtl/sdctl_dp.sv
module sdctl_dp
  import sdctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RCD   = 2,
  parameter int T_RC    = 7,
  parameter int T_MRD   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobe_t                      stb,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]               reqWdata,
  input  logic [DATA_W/8-1:0]             reqMask,
  output logic                            sdCsN,
  output logic                            sdRasN,
  output logic                            sdCasN,
  output logic                            sdWeN,
  output logic [ROW_W-1:0]                sdAddr,
  output logic                            sdAutoPre,
  output logic [BANK_W-1:0]               sdBank,
  output logic [DATA_W/8-1:0]             sdDqm,
  output logic [DATA_W-1:0]               sdDqOut,
  output logic                            sdDqOe,
  input  logic [DATA_W-1:0]               sdDqIn,
  output logic                            rspValid,
  output logic [DATA_W-1:0]               rspData
);

  localparam int MASK_W = DATA_W / 8;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
  localparam int SAT   = maxOf(T_RC, maxOf(T_MRD, T_RCD)) + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  sdCmd_e              cmdQ;
  logic [COL_W-1:0]    holdCol;
  logic [BANK_W-1:0]   holdBank;
  logic [DATA_W-1:0]   holdWdata;
  logic [MASK_W-1:0]   holdMask;
  logic [ROW_W-1:0]    rowN;
  logic [BANK_W-1:0]   bankN;
  logic [CAS_LAT-1:0]  rdPipe;
  logic [CNT_W-1:0]    sinceAct, sinceMrs;

  always_comb begin
    rowN  = '0;
    bankN = '0;
    unique case (stb.addrSel)
      ADDR_ROW: begin
        rowN  = reqAddr[COL_W +: ROW_W];
        bankN = reqAddr[COL_W+ROW_W +: BANK_W];
      end
      ADDR_COL: begin
        rowN  = ROW_W'(holdCol);
        bankN = holdBank;
      end
      ADDR_MODE: rowN = MODE_WORD;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= CMD_DESEL;
      sdAddr    <= '0;
      sdAutoPre <= 1'b0;
      sdBank    <= '0;
      sdDqm     <= '0;
      sdDqOut   <= '0;
      sdDqOe    <= 1'b0;
      holdCol   <= '0;
      holdBank  <= '0;
      holdWdata <= '0;
      holdMask  <= '0;
      rdPipe    <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
    end else begin
      cmdQ      <= stb.cmd;
      sdAddr    <= rowN;
      sdAutoPre <= stb.apBit;
      sdBank    <= bankN;
      if (stb.takeReq) begin
        holdCol   <= reqAddr[COL_W-1:0];
        holdBank  <= reqAddr[COL_W+ROW_W +: BANK_W];
        holdWdata <= reqWdata;
        holdMask  <= reqMask;
      end
      if (stb.cmd == CMD_WR) begin
        sdDqOut <= holdWdata;
        sdDqm   <= holdMask;
        sdDqOe  <= 1'b1;
      end else begin
        sdDqm  <= '0;
        sdDqOe <= 1'b0;
      end
      rdPipe   <= {rdPipe[CAS_LAT-2:0], stb.cmd == CMD_RD};
      rspValid <= rdPipe[CAS_LAT-1];
      if (rdPipe[CAS_LAT-1]) rspData <= sdDqIn;
    end
  end

  assign sdCsN  = cmdQ[3];
  assign sdRasN = cmdQ[2];
  assign sdCasN = cmdQ[1];
  assign sdWeN  = cmdQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= CNT_W'(SAT);
      sinceMrs <= CNT_W'(SAT);
    end else begin
      if (cmdQ == CMD_ACT) sinceAct <= CNT_W'(1);
      else if (sinceAct != CNT_W'(SAT)) sinceAct <= sinceAct + 1'b1;
      if (cmdQ == CMD_MRS) sinceMrs <= CNT_W'(1);
      else if (sinceMrs != CNT_W'(SAT)) sinceMrs <= sinceMrs + 1'b1;
    end
  end

  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rstN) (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> sinceAct == CNT_W'(T_RCD)) else $error("column command off activate spacing"); // R5
  AST_RC_MET: assert property (@(posedge clk) disable iff (!rstN) (cmdQ == CMD_ACT) |-> sinceAct >= CNT_W'(T_RC)) else $error("activates too close"); // R8
  AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rstN) (cmdQ == CMD_ACT) |-> sinceMrs >= CNT_W'(T_MRD)) else $error("activate too soon after mode set"); // R2
  AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> $past(cmdQ == CMD_RD, CAS_LAT)) else $error("response without read"); // R7
  AST_WR_ONLY_DRIVE: assert property (@(posedge clk) disable iff (!rstN) sdDqOe |-> (cmdQ == CMD_WR && sdAutoPre)) else $error("bus driven outside write"); // R6

endmodule

// File: rtl/sdctl_top.sv
module sdctl_top
  import sdctl_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int BANK_W       = 2,
  parameter int CAS_LAT      = 2,
  parameter int INIT_CYC     = 10000,
  parameter int REF_INTERVAL = 780,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_RDL        = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqMask,
  output logic                          rspValid,
  output logic [DATA_W-1:0]             rspData,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [ROW_W-1:0]              sdAddr,
  output logic                          sdAutoPre,
  output logic [BANK_W-1:0]             sdBank,
  output logic [DATA_W/8-1:0]           sdDqm,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe,
  input  logic [DATA_W-1:0]             sdDqIn
);

  ctlStrobe_t stb;

  sdctl_ctrl #(
    .INIT_CYC(INIT_CYC), .REF_INTERVAL(REF_INTERVAL), .CAS_LAT(CAS_LAT),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_RCD(T_RCD),
    .T_RAS(T_RAS), .T_RC(T_RC), .T_RDL(T_RDL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sdctl_dp #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RC(T_RC), .T_MRD(T_MRD)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdAddr(sdAddr), .sdAutoPre(sdAutoPre), .sdBank(sdBank),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/sim_sdctl_top.sv
`timescale 1ns/1ps
module sim_sdctl_top;

  localparam int CL    = 3;
  localparam int INITC = 24;
  localparam int REFI  = 17;
  localparam int TRP = 2, TRFC = 7, TMRD = 2, TRCD = 2, TRAS = 5, TRC = 7, TRDL = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [21:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqMask = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        sdCsN, sdRasN, sdCasN, sdWeN, sdAutoPre, sdDqOe;
  logic [11:0] sdAddr;
  logic [1:0]  sdBank;
  logic [3:0]  sdDqm;
  logic [31:0] sdDqOut;
  logic [31:0] sdDqIn = 32'h0BAD_F00D;

  always #2 clk = ~clk;

  sdctl_top #(
    .CAS_LAT(CL), .INIT_CYC(INITC), .REF_INTERVAL(REFI),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD), .T_RAS(TRAS), .T_RC(TRC), .T_RDL(TRDL)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask), .rspValid(rspValid),
    .rspData(rspData), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdAutoPre(sdAutoPre), .sdBank(sdBank), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference state
  int cyc = 0;
  bit initDone = 0;
  int initStep = 0, nextInit = INITC, initLastRef = 0;
  int postCmds = 0, runRefs = 0;
  int lastAct = -1000, lastAccess = -1000, lastRef = -1000;
  int postGap;
  logic [3:0] expInit [4] = '{4'b0010, 4'b0001, 4'b0000, 4'b0001};
  int initGap [4];
  bit          qWr [$];
  logic [21:0] qAddr [$];
  logic [31:0] qData [$];
  logic [3:0]  qMask [$];
  int          drvCyc [$];
  logic [31:0] drvData [$];
  int          rspCyc [$];
  logic [31:0] rspExp [$];
  logic [31:0] mem [int];

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    initGap = '{INITC, TRP, TRFC, TMRD};
    postGap = imax(imax(TRC - TRCD, TRAS - TRCD + TRP), imax(CL + TRP, TRDL + TRP));
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [3:0] cmd;
      cyc++;
      cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
      // memory model data return
      if (drvCyc.size() > 0 && drvCyc[0] == cyc) begin
        sdDqIn = drvData[0];
        void'(drvCyc.pop_front()); void'(drvData.pop_front());
      end else sdDqIn = 32'h0BAD_F00D;
      // read responses
      if (rspCyc.size() > 0 && rspCyc[0] == cyc) begin
        chk(rspValid == 1'b1, "R7", "rspValid at latency", {31'b0, rspValid}, 32'd1);
        chk(rspData == rspExp[0], "R7", "read data", rspData, rspExp[0]);
        void'(rspCyc.pop_front()); void'(rspExp.pop_front());
      end else if (rspValid) chk(1'b0, "R7", "unexpected rspValid", 32'd1, 32'd0);
      if (sdDqOe) chk(cmd == 4'b0100, "R6", "bus driven off write", {28'b0, cmd}, 32'h4);
      if (!initDone) begin
        chk(reqReady == 1'b0, "R2", "ready during start-up", {31'b0, reqReady}, 32'd0);
        if (cmd != 4'b0111 || cyc == nextInit) begin
          chk(cmd == expInit[initStep] && cyc == nextInit, initStep == 0 ? "R1" : "R2",
              "start-up command/cycle", {cmd, 28'(cyc)}, {expInit[initStep], 28'(nextInit)});
          if (initStep == 0) chk(sdAutoPre == 1'b1, "R2", "precharge-all bit", {31'b0, sdAutoPre}, 32'd1);
          if (initStep == 2) begin
            chk(sdAddr == 12'(CL << 4), "R3", "mode word", {20'b0, sdAddr}, 32'(CL << 4));
            chk(sdBank == 2'b00, "R3", "mode bank", {30'b0, sdBank}, 32'd0);
          end
          initStep++;
          if (initStep == 4) begin
            initDone = 1; initLastRef = cyc; lastRef = cyc;
          end else nextInit = cyc + initGap[initStep];
        end
      end else if (cmd != 4'b0111) begin
        postCmds++;
        if (postCmds <= 2)
          chk(cmd == 4'b0001 && cyc == initLastRef + postCmds * TRFC, "R9",
              "owed refresh pair after start-up", {cmd, 28'(cyc)}, {4'b0001, 28'(initLastRef + postCmds * TRFC)});
        case (cmd)
          4'b0001: begin
            runRefs++;
            chk(cyc - lastAccess >= postGap && cyc - lastRef >= TRFC, "R8", "refresh spacing",
                32'(cyc - lastAccess), 32'(postGap));
            lastRef = cyc;
          end
          4'b0011: begin
            chk(cyc - lastAct >= TRC && cyc - lastAccess >= postGap && cyc - lastRef >= TRFC, "R8",
                "activate spacing", 32'(cyc - lastAct), 32'(TRC));
            if (qAddr.size() > 0)
              chk({sdBank, sdAddr} == qAddr[0][21:8], "R4", "bank/row", {18'b0, sdBank, sdAddr}, {18'b0, qAddr[0][21:8]});
            else chk(1'b0, "R4", "activate without request", 32'd1, 32'd0);
            lastAct = cyc;
          end
          4'b0100, 4'b0101: begin
            chk(cyc - lastAct == TRCD, "R5", "activate to column", 32'(cyc - lastAct), 32'(TRCD));
            chk(sdAutoPre == 1'b1, "R5", "auto-precharge bit", {31'b0, sdAutoPre}, 32'd1);
            if (qAddr.size() > 0) begin
              int key;
              key = int'(qAddr[0]);
              chk({sdBank, sdAddr} == {qAddr[0][21:20], 4'b0, qAddr[0][7:0]}, "R5", "bank/column",
                  {18'b0, sdBank, sdAddr}, {18'b0, qAddr[0][21:20], 4'b0, qAddr[0][7:0]});
              chk((cmd == 4'b0100) == qWr[0], "R5", "read/write kind", {28'b0, cmd}, qWr[0] ? 32'h4 : 32'h5);
              if (cmd == 4'b0100) begin
                logic [31:0] old;
                chk(sdDqOe && sdDqOut == qData[0], "R6", "write data", sdDqOut, qData[0]);
                chk(sdDqm == qMask[0], "R6", "byte mask", {28'b0, sdDqm}, {28'b0, qMask[0]});
                old = mem.exists(key) ? mem[key] : 32'h0;
                for (int b = 0; b < 4; b++)
                  if (!sdDqm[b]) old[8*b +: 8] = sdDqOut[8*b +: 8];
                mem[key] = old;
              end else begin
                drvCyc.push_back(cyc + CL - 1);
                drvData.push_back(mem.exists(key) ? mem[key] : 32'h0);
                rspCyc.push_back(cyc + CL);
                rspExp.push_back(mem.exists(key) ? mem[key] : 32'h0);
              end
              void'(qWr.pop_front()); void'(qAddr.pop_front());
              void'(qData.pop_front()); void'(qMask.pop_front());
            end
            lastAccess = cyc;
          end
          default: chk(1'b0, "R8", "illegal command", {28'b0, cmd}, 32'h7);
        endcase
      end else begin
        vectors++;
      end
      if (cyc > 20000) begin
        chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'd20000);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  task automatic issue(input bit wr, input logic [21:0] a, input logic [31:0] d, input logic [3:0] m);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    qWr.push_back(wr); qAddr.push_back(a); qData.push_back(d); qMask.push_back(m);
    @(negedge clk);
    chk(reqReady == 1'b0, "R4", "ready after accept", {31'b0, reqReady}, 32'd0);
    reqValid = 1'b0;
  endtask

  initial begin
    int startRun;
    repeat (4) @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b1111, "R1", "deselect in reset",
        {28'b0, sdCsN, sdRasN, sdCasN, sdWeN}, 32'hF);
    #1 rstN = 1'b1;
    // request waits through start-up and the two owed refreshes (R9)
    issue(1'b1, {2'd0, 12'h000, 8'h00}, 32'h1122_3344, 4'b0000);
    issue(1'b1, {2'd3, 12'hFFF, 8'hFF}, 32'hCAFE_F00D, 4'b0000);
    issue(1'b1, {2'd1, 12'h5A5, 8'h10}, 32'hA5A5_5A5A, 4'b0000);
    issue(1'b0, {2'd0, 12'h000, 8'h00}, 32'h0, 4'b0);
    issue(1'b0, {2'd3, 12'hFFF, 8'hFF}, 32'h0, 4'b0);
    // masked write keeps bytes 0 and 2 (R6)
    issue(1'b1, {2'd1, 12'h5A5, 8'h10}, 32'h0102_0304, 4'b0101);
    issue(1'b0, {2'd1, 12'h5A5, 8'h10}, 32'h0, 4'b0);
    issue(1'b1, {2'd2, 12'h001, 8'h80}, 32'hDEAD_BEEF, 4'b1111);
    issue(1'b0, {2'd2, 12'h001, 8'h80}, 32'h0, 4'b0);
    startRun = cyc;
    for (int i = 0; i < 40; i++) begin
      logic [21:0] a;
      a = {2'(i), 12'(i * 37), 8'(i * 11)};
      issue(1'b1, a, 32'h1000_0000 + 32'(i * 7919), 4'(i % 3 == 0 ? 4'b1000 : 4'b0000));
      issue(1'b0, a, 32'h0, 4'b0);
    end
    repeat (20) @(negedge clk);
    chk(rspCyc.size() == 0 && qAddr.size() == 0, "R7", "all responses returned",
        32'(rspCyc.size()), 32'd0);
    chk(runRefs >= (cyc - startRun) / REFI, "R9", "refresh rate under load",
        32'(runRefs), 32'((cyc - startRun) / REFI));
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule